// File: doc/BRIEF.md
# Error-Diffusion Gray-Scale Reducer

This block takes 8-bit-per-channel RGB video and reduces every channel to 3, 4, 5 or 6 bits for a flat-panel source driver. The levels that are lost are hidden by error diffusion. Each pixel's quantisation error is carried into the next pixel on the same line and into the pixel in the same column on the following line. A small line memory inside the block holds that second share. In the depth modes meant for plain panels, the rounding threshold also moves from frame to frame, driven by a 2-bit frame counter. This spreads the residual error over time.

Line and frame boundaries come only from the horizontal and vertical sync inputs, so no resolution is built in. The line memory depth is a parameter, and columns beyond it simply get no vertical error share. A bypass input truncates the pixel instead of diffusing it. A power-save input stops all processing while the sync and enable signals still pass through. Sync and enable always leave the block with the same one-cycle delay as the data.

Top module: `grayscale_reducer`

## Requirements
- R1: The mode code `mode_i` sets the output depth N and whether frame-to-frame bias is used. Codes 0, 1, 2 and 3 give N = 3, 4, 5 and 6 with the frame bias. Codes 5, 6 and 7 give N = 4, 5 and 6 with a fixed bias. Code 4 acts like code 5. Each output field holds its N-bit value in its low bits, with the unused upper bits zero. The fields are red in `rgb_o[17:12]`, green in `[11:6]` and blue in `[5:0]`. The input fields are red in `rgb_i[23:16]`, green in `[15:8]` and blue in `[7:0]`.
- R2: A pixel sampled at a clock edge appears on `rgb_o` right after that same edge.
- R3: The shift S is 8−N. The sum is v = pixel + floor(eh/2) + floor(ev/2). The output is q = floor((v+b)/2^S), clamped to the range 0..2^N−1 with no wraparound. The error is e = v − q·2^S, clamped to the range −128..127.
- R4: eh is the error of the previous active pixel on the same line. It is zero for the first pixel after a horizontal or vertical sync.
- R5: ev is the error stored for the same column on the previous line of the frame. It is zero on the first line after vertical sync, and zero in every column at or beyond `LINE_W`. Those columns store nothing.
- R6: With the fixed bias, b = 2^(S−1). With the frame bias, b = f·2^(S−2), where f is a 2-bit frame count. The count is 0 after reset and steps by one on each rising edge of `vsync_i` outside power-save.
- R7: `hsync_o`, `vsync_o` and `de_o` repeat their inputs one cycle later in every mode, power-save included.
- R8: A cycle is active when `de_i` is high and both syncs are low. `rgb_o` is zero after any cycle that is not active.
- R9: With `bypass_i` high on an active cycle, q = pixel >> S. The error passed on and stored for that pixel is zero.
- R10: With `pwr_save_i` high, `rgb_o` is zero. The error state, the column position, the line history and the frame count all hold.
- R11: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| de_i | input | 1 | Data enable |
| rgb_i | input | 24 | Input pixel, 8 bits per channel |
| mode_i | input | 3 | Depth and diffusion mode code |
| pwr_save_i | input | 1 | Stop processing; pass sync and enable only |
| bypass_i | input | 1 | Truncate instead of diffusing |
| rgb_o | output | 18 | Reduced pixel, 6-bit field per channel |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed data enable |

## Verification
Every result of this block is due exactly one clock after the edge that samples its input. This covers the reduced pixel, the blanking zeros, and the delayed sync and enable. State effects land at that same edge: the horizontal error, the line-memory write, the column step and the frame-count step. The next pixel sees them at once. The bench drives each vector on a falling edge and advances its own model by that one vector. It compares the outputs on the following falling edge, after exactly one rising edge, so each comparison meets the single-cycle result of the vector just applied.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  localparam int PIX_W = 8;
  localparam int OUT_W = 6;
  localparam int ERR_W = 8;
  localparam int NCH   = 3;

  typedef struct packed {
    logic [2:0]       shift;
    logic [OUT_W-1:0] qmax;
    logic             temporal;
  } depth_t;

  function automatic depth_t decode_mode(input logic [2:0] code);
    depth_t d;
    int     n;
    if (!code[2]) n = 3 + int'(code[1:0]);
    else if (code[1:0] == 2'd0) n = 4;
    else n = 3 + int'(code[1:0]);
    d.shift    = 3'(PIX_W - n);
    d.qmax     = OUT_W'((1 << n) - 1);
    d.temporal = ~code[2];
    return d;
  endfunction
endpackage

// File: rtl/gsr_quant.sv
module gsr_quant
  import gsr_pkg::*;
(
  input  logic [PIX_W-1:0]        pix_i,
  input  logic signed [ERR_W-1:0] eh_i,
  input  logic signed [ERR_W-1:0] ev_i,
  input  logic [2:0]              shift_i,
  input  logic [4:0]              bias_i,
  input  logic [OUT_W-1:0]        qmax_i,
  input  logic                    bypass_i,
  output logic [OUT_W-1:0]        q_o,
  output logic signed [ERR_W-1:0] err_o
);
  logic signed [10:0] pix_x, eh_x, ev_x, sum, tot, qr, rem;

  always_comb begin
    pix_x = $signed({3'b000, pix_i});
    eh_x  = $signed({{3{eh_i[ERR_W-1]}}, eh_i});
    ev_x  = $signed({{3{ev_i[ERR_W-1]}}, ev_i});
    sum   = pix_x + (eh_x >>> 1) + (ev_x >>> 1);
    tot   = sum + $signed({6'b000000, bias_i});
    qr    = tot >>> shift_i;
    if (qr < 0)                               q_o = '0;
    else if (qr > $signed({5'b00000, qmax_i})) q_o = qmax_i;
    else                                      q_o = qr[OUT_W-1:0];
    rem = sum - ($signed({5'b00000, q_o}) <<< shift_i);
    if (rem > 11'sd127)       err_o = 8'sd127;
    else if (rem < -11'sd128) err_o = -8'sd128;
    else                      err_o = rem[ERR_W-1:0];
    if (bypass_i) begin
      q_o   = OUT_W'(pix_i >> shift_i);
      err_o = '0;
    end
  end
endmodule

// File: rtl/gsr_errline.sv
module gsr_errline #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 24,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/grayscale_reducer.sv
module grayscale_reducer
  import gsr_pkg::*;
#(
  parameter int LINE_W = 128,
  localparam int COL_W = $clog2(LINE_W + 1),
  localparam int AW    = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hsync_i,
  input  logic                   vsync_i,
  input  logic                   de_i,
  input  logic [NCH*PIX_W-1:0]   rgb_i,
  input  logic [2:0]             mode_i,
  input  logic                   pwr_save_i,
  input  logic                   bypass_i,
  output logic [NCH*OUT_W-1:0]   rgb_o,
  output logic                   hsync_o,
  output logic                   vsync_o,
  output logic                   de_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  // state
  logic [1:0]                       fc, fc_n;
  logic                             vs_q;
  logic                             row_valid, row_valid_n;
  logic                             seen, seen_n;
  logic [COL_W-1:0]                 col, col_n;
  logic [NCH-1:0][ERR_W-1:0]        eh, eh_n;
  logic [NCH*OUT_W-1:0]             rgb_n;

  // datapath
  depth_t                    dep;
  logic [4:0]                bias;
  logic                      run, active, col_ok, mem_we;
  logic [NCH*ERR_W-1:0]      mem_rd, mem_wd;
  logic [NCH-1:0][ERR_W-1:0] ev, err;
  logic [NCH-1:0][OUT_W-1:0] q;
  logic [AW-1:0]             addr;
  logic [7:0]                fc8;

  always_comb begin
    dep    = decode_mode(mode_i);
    fc8    = {6'b000000, fc};
    bias   = dep.temporal ? 5'((fc8 << dep.shift) >> 2)
                          : 5'(8'd1 << (dep.shift - 3'd1));
    run    = ~pwr_save_i;
    active = de_i & ~hsync_i & ~vsync_i;
    col_ok = (col < COL_W'(LINE_W));
    addr   = col_ok ? AW'(col) : '0;
  end

  gsr_errline #(.DEPTH(LINE_W), .DATA_W(NCH*ERR_W)) u_errline (
    .clk    (clk),
    .we_i   (mem_we),
    .addr_i (addr),
    .wdata_i(mem_wd),
    .rdata_o(mem_rd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ev[c] = (row_valid && col_ok) ? mem_rd[c*ERR_W +: ERR_W] : '0;
    assign mem_wd[c*ERR_W +: ERR_W] = err[c];
    gsr_quant u_quant (
      .pix_i   (rgb_i[(NCH-1-c)*PIX_W +: PIX_W]),
      .eh_i    (eh[c]),
      .ev_i    (ev[c]),
      .shift_i (dep.shift),
      .bias_i  (bias),
      .qmax_i  (dep.qmax),
      .bypass_i(bypass_i),
      .q_o     (q[c]),
      .err_o   (err[c])
    );
    assign rgb_n[(NCH-1-c)*OUT_W +: OUT_W] = (run && active) ? q[c] : '0;
  end

  // next state
  always_comb begin
    fc_n        = fc;
    row_valid_n = row_valid;
    seen_n      = seen;
    col_n       = col;
    eh_n        = eh;
    mem_we      = 1'b0;
    if (run) begin
      if (vsync_i && !vs_q) fc_n = fc + 2'd1;
      if (vsync_i) begin
        row_valid_n = 1'b0;
        seen_n      = 1'b0;
        col_n       = '0;
        eh_n        = '0;
      end else if (hsync_i) begin
        if (seen) row_valid_n = 1'b1;
        seen_n = 1'b0;
        col_n  = '0;
        eh_n   = '0;
      end else if (de_i) begin
        seen_n = 1'b1;
        eh_n   = err;
        mem_we = col_ok;
        if (col_ok) col_n = col + COL_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fc        <= '0;
      vs_q      <= 1'b0;
      row_valid <= 1'b0;
      seen      <= 1'b0;
      col       <= '0;
      eh        <= '0;
      rgb_o     <= '0;
      hsync_o   <= 1'b0;
      vsync_o   <= 1'b0;
      de_o      <= 1'b0;
    end else begin
      fc        <= fc_n;
      vs_q      <= vsync_i;
      row_valid <= row_valid_n;
      seen      <= seen_n;
      col       <= col_n;
      eh        <= eh_n;
      rgb_o     <= rgb_n;
      hsync_o   <= hsync_i;
      vsync_o   <= vsync_i;
      de_o      <= de_i;
    end
  end

  // R7
  hs_hi_chk: assert property (@(posedge clk) disable iff (!rst_s) hsync_i |=> hsync_o);
  // R7
  de_lo_chk: assert property (@(posedge clk) disable iff (!rst_s) !de_i |=> !de_o);
  // R8
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !de_i |=> (rgb_o == '0));
  // R10
  pwrsave_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    pwr_save_i |=> (rgb_o == '0));
  // R10
  fc_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    pwr_save_i |=> $stable(fc));
  // R6
  fc_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (vsync_i && !vs_q && !pwr_save_i) |=> (fc == $past(fc) + 2'd1));
  // R1
  depth3_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_i == 3'd0) |=> (rgb_o[17:15] == 3'd0 && rgb_o[11:9] == 3'd0 && rgb_o[5:3] == 3'd0));
endmodule

// File: tb/test_grayscale_reducer.sv
`timescale 1ns/1ps
module test_grayscale_reducer;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hsync_i, vsync_i, de_i, pwr_save_i, bypass_i;
  logic [23:0] rgb_i;
  logic [2:0]  mode_i;
  logic [17:0] rgb_o;
  logic        hsync_o, vsync_o, de_o;

  int vectors = 0;
  int fails   = 0;

  // model state
  int m_eh [3];
  int m_mem[3][W];
  int m_col, m_fc;
  bit m_rv, m_seen, m_vsq;

  always #2.5 clk = ~clk;

  grayscale_reducer #(.LINE_W(W)) i_grayscale_reducer (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
    .rgb_i(rgb_i), .mode_i(mode_i), .pwr_save_i(pwr_save_i), .bypass_i(bypass_i),
    .rgb_o(rgb_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
  );

  function automatic int depth_of(input logic [2:0] md);
    case (md)
      3'd0: return 3;  3'd1: return 4;  3'd2: return 5;  3'd3: return 6;
      3'd4: return 4;  3'd5: return 4;  3'd6: return 5;  default: return 6;
    endcase
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic check(input string tag, input logic [17:0] exp_rgb,
                       input logic [2:0] exp_sync);
    vectors++;
    if (rgb_o !== exp_rgb) begin
      fails++;
      $display("FAIL %s rgb_o actual=%h expected=%h", tag, rgb_o, exp_rgb);
    end else if ({hsync_o, vsync_o, de_o} !== exp_sync) begin
      fails++;
      $display("FAIL R7 sync actual=%b expected=%b", {hsync_o, vsync_o, de_o}, exp_sync);
    end
  endtask

  // one vector: drive on falling edge, result due after the next rising edge
  task automatic step(input logic hs, vs, de, input logic [23:0] rgb,
                      input logic [2:0] md, input logic ps, byp);
    logic [17:0] exp_rgb = '0;
    int    n, s, b, tmp, ev, v, q, e;
    string tag;
    hsync_i = hs; vsync_i = vs; de_i = de; rgb_i = rgb;
    mode_i = md; pwr_save_i = ps; bypass_i = byp;
    n   = depth_of(md);
    s   = 8 - n;
    tmp = (md < 3'd4) ? 1 : 0;
    if (ps) tag = "R10";
    else if (!(de && !hs && !vs)) tag = "R8";
    else if (byp) tag = "R9";
    else if (tmp == 1) tag = "R1 R2 R3 R4 R5 R6";
    else tag = "R1 R2 R3 R4 R5";
    if (!ps) begin
      if (vs && !m_vsq) m_fc = (m_fc + 1) % 4;
      if (vs) begin
        m_rv = 0; m_seen = 0; m_col = 0;
        for (int c = 0; c < 3; c++) m_eh[c] = 0;
      end else if (hs) begin
        if (m_seen) m_rv = 1;
        m_seen = 0; m_col = 0;
        for (int c = 0; c < 3; c++) m_eh[c] = 0;
      end else if (de) begin
        b = (tmp == 1) ? (m_fc * (1 << s)) / 4 : (1 << s) / 2;
        for (int c = 0; c < 3; c++) begin
          int pix;
          pix = int'(rgb[23-8*c -: 8]);
          ev  = (m_rv && m_col < W) ? m_mem[c][m_col] : 0;
          if (byp) begin
            q = pix >> s; e = 0;
          end else begin
            v = pix + (m_eh[c] >>> 1) + (ev >>> 1);
            q = clampi((v + b) >>> s, 0, (1 << n) - 1);
            e = clampi(v - q * (1 << s), -128, 127);
          end
          exp_rgb[17-6*c -: 6] = 6'(q);
          m_eh[c] = e;
          if (m_col < W) m_mem[c][m_col] = e;
        end
        if (m_col < W) m_col++;
        m_seen = 1;
      end
    end
    m_vsq = vs;
    @(posedge clk);
    @(negedge clk);
    check(tag, exp_rgb, {hs, vs, de});
  endtask

  // kind: 0 random, 1 saturation corners, 2 bypass on line 1, 3 power-save on line 1
  task automatic frame(input logic [2:0] md, input int lines, input int len, input int kind);
    step(0, 1, 0, '0, md, 0, 0);
    step(0, 1, 0, '0, md, 0, 0);
    step(0, 0, 0, '0, md, 0, 0);
    for (int l = 0; l < lines; l++) begin
      logic ps  = (kind == 3 && l == 1);
      logic byp = (kind == 2 && l == 1);
      step(1, 0, 0, '0, md, ps, byp);
      step(0, 0, 0, '0, md, ps, byp);
      for (int p = 0; p < len; p++) begin
        logic [23:0] px = $urandom;
        if (kind == 1 && l == 0) px = 24'hFFFFFF;
        if (kind == 1 && l == 1) px = 24'h000000;
        step(0, 0, 1, px, md, ps, byp);
      end
      step(0, 0, 0, $urandom, md, ps, byp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_fc = 0; m_col = 0; m_rv = 0; m_seen = 0; m_vsq = 0;
    for (int c = 0; c < 3; c++) begin
      m_eh[c] = 0;
      for (int k = 0; k < W; k++) m_mem[c][k] = 0;
    end
    rst_n = 1'b0; hsync_i = 0; vsync_i = 0; de_i = 0;
    rgb_i = 24'hA5A5A5; mode_i = 3'd0; pwr_save_i = 0; bypass_i = 0;
    repeat (3) @(negedge clk);
    // R11: outputs zero while reset is held
    check("R11", '0, 3'b000);
    rgb_i = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners: saturation at both ends, bypass, power-save freeze
    frame(3'd0, 3, 10, 1);
    frame(3'd7, 3, 10, 1);
    frame(3'd1, 3, 12, 2);
    frame(3'd2, 4, 12, 3);
    frame(3'd5, 3, 20, 0);   // lines wider than the line memory (R5)
    // constrained random over every mode code
    for (int r = 0; r < 3; r++) begin
      for (int m = 0; m < 8; m++) begin
        frame(3'(m), 3 + int'($urandom % 3), 6 + int'($urandom % 16), int'($urandom % 4));
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule